// File: doc/BRIEF.md
# Debug Status Trace Message Generator

This block watches a core's debug-mode and low-power-mode signals. Whenever trace is enabled and one of these modes changes in a qualifying way, it builds a fixed 18-bit trace message. A qualifying change is entering debug mode, leaving debug mode, or entering low-power mode. Each message holds a zero type code, a 4-bit source identifier and an 8-bit status byte. The status byte is the top byte of the development status word, sampled in the cycle the mode change is seen.

Messages pass to a trace output stage as parallel words under a valid/ready handshake. A small queue holds messages that arrive while the output stage is stalled. Events that find the queue full are dropped, and a sticky overflow flag records the loss until reset. Bit 0 of the word is the bit sent first by any serialiser downstream.

Top module: `dbg_status_msg_gen`

## Requirements
- R1: After reset, msg_valid_o and overflow_o are 0, and no message appears while the mode inputs stay at 0.
- R2: While trace_en_i is 1, a 0-to-1 change of dbg_mode_i queues one message. The message is valid at the first clock edge after the edge at which the new level is sampled. Its fields are: bits 5:0 = 000000, bits 9:6 = src_id_i, and bits 17:10 = status_i, with src_id_i and status_i sampled at the edge where the change is detected.
- R3: While trace_en_i is 1, a 1-to-0 change of dbg_mode_i queues one message with the same field layout.
- R4: While trace_en_i is 1, a 0-to-1 change of lp_mode_i queues one message. A 1-to-0 change of lp_mode_i queues nothing.
- R5: While trace_en_i is 0, mode changes queue nothing and never set overflow_o. Such changes are also not reported after trace_en_i later returns to 1.
- R6: A debug-mode change and a low-power entry detected at the same edge queue exactly one message.
- R7: The queue holds up to 2 messages and delivers them oldest first. While msg_valid_o is 1 and msg_ready_i is 0, msg_valid_o stays 1 and msg_data_o stays unchanged.
- R8: An event that finds the queue full while no message is taken at that edge is dropped. It sets overflow_o, which then stays 1 until reset.
- R9: An event that finds the queue full while a message is taken at that same edge is accepted, and overflow_o stays 0.
- R10: A change of status_i or src_id_i with no mode change queues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_en_i | input | 1 | Trace enable |
| dbg_mode_i | input | 1 | Core is in debug mode |
| lp_mode_i | input | 1 | Core is in a low-power mode |
| status_i | input | 8 | Top byte of the development status word |
| src_id_i | input | 4 | Source identifier placed in each message |
| msg_valid_o | output | 1 | A message is offered |
| msg_data_o | output | 18 | Offered message, bit 0 sent first |
| msg_ready_i | input | 1 | Output stage takes the message at the clock edge |
| overflow_o | output | 1 | Sticky flag: an event was lost |

## Verification
The queue can receive a new event at the same edge at which the output stage takes the oldest message. This matters most when the queue is already full. The bench fills both entries with msg_ready_i held low. It then drives a fresh debug-mode change in the same half-cycle that it raises msg_ready_i. Afterwards it checks that overflow_o stayed 0 and that the remaining and new messages come out in order with their computed fields. A matching case with msg_ready_i low must drop the event and raise the flag.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int unsigned TCODE_W = 6;
  localparam logic [TCODE_W-1:0] TCODE_DBG_STATUS = '0;

  function automatic logic [TCODE_W+4+8-1:0] pack_msg(input logic [3:0] src,
                                                      input logic [7:0] stat);
    return {stat, src, TCODE_DBG_STATUS};
  endfunction
endpackage

// File: rtl/dsm_edge_det.sv
module dsm_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dbg_i,
  input  logic lp_i,
  output logic event_o
);
  logic dbg_q, lp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_q <= 1'b0;
      lp_q  <= 1'b0;
    end else begin
      dbg_q <= dbg_i;
      lp_q  <= lp_i;
    end
  end

  // debug entry/exit, low-power entry only
  assign event_o = (dbg_i ^ dbg_q) | (lp_i & ~lp_q);

  // R4
  lp_exit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_q && !lp_i && dbg_i == dbg_q) |-> !event_o);
endmodule

// File: rtl/dsm_msg_fifo.sv
module dsm_msg_fifo #(
  parameter int unsigned WIDTH = 18,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             accept_o,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  input  logic             ready_i
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W:0]   DEPTH_C = DEPTH[PTR_W:0];
  localparam logic [PTR_W-1:0] LAST_C  = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [PTR_W:0]   cnt_q;
  logic             pop, wr;

  assign valid_o  = (cnt_q != '0);
  assign data_o   = mem_q[rd_q];
  assign pop      = valid_o & ready_i;
  assign accept_o = (cnt_q != DEPTH_C) | pop;
  assign wr       = push_i & accept_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr)  wr_q <= (wr_q == LAST_C) ? '0 : wr_q + 1'b1;
      if (pop) rd_q <= (rd_q == LAST_C) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + {{PTR_W{1'b0}}, wr} - {{PTR_W{1'b0}}, pop};
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (wr && wr_q == PTR_W'(g))       mem_q[g] <= data_i;
    end
  end

  // R7
  hold_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
  // R7
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= DEPTH_C);
endmodule

// File: rtl/dbg_status_msg_gen.sv
module dbg_status_msg_gen #(
  parameter int unsigned SRC_W  = 4,
  parameter int unsigned STAT_W = 8,
  parameter int unsigned DEPTH  = 2
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   trace_en_i,
  input  logic                                   dbg_mode_i,
  input  logic                                   lp_mode_i,
  input  logic [STAT_W-1:0]                      status_i,
  input  logic [SRC_W-1:0]                       src_id_i,
  output logic                                   msg_valid_o,
  output logic [STAT_W+SRC_W+dsm_pkg::TCODE_W-1:0] msg_data_o,
  input  logic                                   msg_ready_i,
  output logic                                   overflow_o
);
  localparam int unsigned MSG_W = STAT_W + SRC_W + dsm_pkg::TCODE_W;

  logic             mode_evt, push, accept;
  logic [MSG_W-1:0] msg_new;
  logic             ovf_q;

  dsm_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dbg_i   (dbg_mode_i),
    .lp_i    (lp_mode_i),
    .event_o (mode_evt)
  );

  assign push    = mode_evt & trace_en_i;
  assign msg_new = {status_i, src_id_i, dsm_pkg::TCODE_DBG_STATUS};

  dsm_msg_fifo #(.WIDTH(MSG_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (push),
    .data_i   (msg_new),
    .accept_o (accept),
    .valid_o  (msg_valid_o),
    .data_o   (msg_data_o),
    .ready_i  (msg_ready_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ovf_q <= 1'b0;
    else if (push && !accept) ovf_q <= 1'b1;
  end
  assign overflow_o = ovf_q;

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);
  // R5
  dis_no_msg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trace_en_i && !msg_valid_o) |=> !msg_valid_o);
  // R5
  dis_no_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trace_en_i && !overflow_o) |=> !overflow_o);
  // R2
  tcode_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msg_data_o[dsm_pkg::TCODE_W-1:0] == '0));
endmodule

// File: tb/sim_dbg_status_msg_gen.sv
`timescale 1ns/1ps
module sim_dbg_status_msg_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, dbg = 1'b0, lp = 1'b0, rdy = 1'b0;
  logic [7:0]  st = 8'h00;
  logic [3:0]  src = 4'h0;
  logic        vld, ovf;
  logic [17:0] dat;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  dbg_status_msg_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .trace_en_i(en), .dbg_mode_i(dbg),
    .lp_mode_i(lp), .status_i(st), .src_id_i(src), .msg_valid_o(vld),
    .msg_data_o(dat), .msg_ready_i(rdy), .overflow_o(ovf)
  );

  function automatic logic [17:0] exp_msg(input logic [3:0] s, input logic [7:0] b);
    return (18'(b) << 10) | (18'(s) << 6);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic pop_one(input string tag, input logic [17:0] e);
    chk(vld === 1'b1, tag, 32'(vld), 1);
    chk(dat === e, tag, 32'(dat), 32'(e));
    rdy = 1'b1; step(); rdy = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 0; dbg = 0; lp = 0; rdy = 0;
    step(); step(); rst_n = 1'b1; step();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    chk(vld === 1'b0, "R1 valid", 32'(vld), 0);
    chk(ovf === 1'b0, "R1 overflow", 32'(ovf), 0);
    step();
    chk(vld === 1'b0, "R1 idle", 32'(vld), 0);

    en = 1'b1;
    // R2 R3 sweep over all source ids and varied status bytes
    for (int s = 0; s < 16; s++) begin
      logic [7:0] b1, b2;
      b1 = 8'((s * 17) ^ 8'h5A);
      b2 = ~b1;
      src = 4'(s); st = b1; dbg = 1'b1;
      step();
      st = 8'h00; src = ~4'(s);
      pop_one("R2 entry", exp_msg(4'(s), b1));
      chk(vld === 1'b0, "R2 single", 32'(vld), 0);
      src = 4'(s); st = b2; dbg = 1'b0;
      step();
      pop_one("R3 exit", exp_msg(4'(s), b2));
      chk(vld === 1'b0, "R3 single", 32'(vld), 0);
    end

    // R4 low-power entry then exit
    src = 4'h3; st = 8'hC3; lp = 1'b1;
    step();
    pop_one("R4 entry", exp_msg(4'h3, 8'hC3));
    lp = 1'b0; st = 8'h11;
    step(); step();
    chk(vld === 1'b0, "R4 exit silent", 32'(vld), 0);

    // R10 status/src changes alone
    for (int k = 0; k < 8; k++) begin
      st = 8'(k * 31); src = 4'(k); step();
      chk(vld === 1'b0, "R10 no event", 32'(vld), 0);
    end

    // R6 simultaneous debug and low-power edges
    src = 4'h9; st = 8'hA5; dbg = 1'b1; lp = 1'b1;
    step();
    pop_one("R6 one msg", exp_msg(4'h9, 8'hA5));
    chk(vld === 1'b0, "R6 only one", 32'(vld), 0);
    dbg = 1'b0; lp = 1'b0; step();
    pop_one("R6 exit msg", exp_msg(4'h9, 8'hA5));

    // R5 disabled: toggles produce nothing, not even later
    en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      dbg = ~dbg; lp = ~lp; step();
      chk(vld === 1'b0, "R5 disabled", 32'(vld), 0);
      chk(ovf === 1'b0, "R5 no overflow", 32'(ovf), 0);
    end
    dbg = 1'b1; lp = 1'b1; step();
    en = 1'b1; step(); step();
    chk(vld === 1'b0, "R5 not replayed", 32'(vld), 0);
    dbg = 1'b0; lp = 1'b0; step();
    pop_one("R5 re-enabled", exp_msg(4'h9, 8'hA5));

    // R7 R8 fill, stall, overflow
    src = 4'h1; st = 8'h10; dbg = 1'b1; step();
    src = 4'h2; st = 8'h20; dbg = 1'b0; step();
    chk(ovf === 1'b0, "R8 not yet", 32'(ovf), 0);
    src = 4'h3; st = 8'h30; lp = 1'b1; step();
    chk(ovf === 1'b1, "R8 set", 32'(ovf), 1);
    step(); step();
    chk(dat === exp_msg(4'h1, 8'h10), "R7 stable", 32'(dat), 32'(exp_msg(4'h1, 8'h10)));
    pop_one("R7 first", exp_msg(4'h1, 8'h10));
    pop_one("R7 second", exp_msg(4'h2, 8'h20));
    chk(vld === 1'b0, "R8 dropped", 32'(vld), 0);
    chk(ovf === 1'b1, "R8 sticky", 32'(ovf), 1);
    lp = 1'b0;
    do_reset();
    chk(ovf === 1'b0, "R1 reset clears", 32'(ovf), 0);

    // R9 full queue with pop in same edge
    en = 1'b1;
    src = 4'h4; st = 8'h44; dbg = 1'b1; step();
    src = 4'h5; st = 8'h55; dbg = 1'b0; step();
    src = 4'h6; st = 8'h66; dbg = 1'b1; rdy = 1'b1; step(); rdy = 1'b0;
    chk(ovf === 1'b0, "R9 no overflow", 32'(ovf), 0);
    pop_one("R9 older", exp_msg(4'h5, 8'h55));
    pop_one("R9 new", exp_msg(4'h6, 8'h66));
    chk(vld === 1'b0, "R9 empty", 32'(vld), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule